// File: doc/BRIEF.md
# Temperature Limit Status and Alert Logic

This block watches four temperature channels, one on-die and three remote, and turns each new set of readings into status bits and two output pins. On every accepted measurement it checks each channel against a per-channel under-temperature limit and a per-channel over-temperature (shutdown) limit. Under-temperature events are latched in a status register that clears when the host reads it. Over-temperature events set a second status register that ignores reads and releases each channel only after its reading drops below the limit minus a programmable hysteresis.

Readings arrive as one packed word per update on a valid/ready stream. The block never applies back-pressure: `meas_ready` stays high, every cycle with `meas_valid` high is one update, and nothing is buffered. The host reaches limits, hysteresis, configuration and status through a single-cycle register port. Read data is combinational, and any read side effect takes place at the clock edge that ends the read cycle. `therm_o` shows any active over-temperature bit. `alert_o` shows latched under-temperature bits, but only after a programmable run of consecutive updates that were out of limit.

Top module: `temp_limit_monitor`

## Requirements
- R1: On an update, low status bit i (channel i at bit i of the register at 0x01; channel 0 is the on-die sensor) is set when the signed 8-bit reading of channel i is below that channel's signed low limit (0x10+i).
- R2: In latching mode (config 0x02 bit 0 = 0), low status bits stay set until a read of 0x01. That read returns the current bits and clears all of them at the end of the read cycle.
- R3: When a read of 0x01 and an update that finds a channel below its low limit fall in the same cycle, that channel's bit is set after the edge. The read itself returns the value from before the edge.
- R4: In follow mode (config bit 0 = 1), each update loads the low status bits with that update's conditions, and reads of 0x01 change nothing.
- R5: On an update, therm status bit i (register 0x37, bit i) is set when the reading is above the signed therm limit (0x20+i). It is cleared when the reading is below the release point, which is that limit minus the unsigned hysteresis (0x03) saturated at -128. Otherwise it holds.
- R6: Reads of 0x37 leave the therm status bits unchanged. Those bits change only on updates.
- R7: Summary register 0x00 reads bit 0 = OR of the low status bits and bit 1 = OR of the therm status bits. Its other bits read 0.
- R8: `therm_o` is high exactly when at least one therm status bit is set.
- R9: A counter counts consecutive updates that have at least one channel below its low limit. It saturates at 4 and returns to 0 on an update with none. `alert_o` is high when the count is at least N (N = config bits 2:1 plus 1) and at least one low status bit is set.
- R10: After reset, the low limits read 0x80, the therm limits read 0x7F, hysteresis reads 0x0A, config reads 0, and both status registers read 0. Writes to the limits, hysteresis and config read back; config keeps only bits 2:0. Unmapped addresses read 0.
- R11: `meas_ready` is high whenever the block is out of reset, so every cycle with `meas_valid` high is taken as an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| meas_valid | input | 1 | A new set of readings is present |
| meas_ready | output | 1 | Block accepts readings (always high out of reset) |
| meas_temp | input | 32 | Signed readings, channel i in bits 8i+7:8i |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| alert_o | output | 1 | Qualified under-temperature alert |
| therm_o | output | 1 | Any channel over its therm limit |

## Verification
The hardest cases to reach from the ports are a clearing read that lands in the same cycle as a fresh under-limit update, and a therm release point pushed below -128 so that saturation decides whether the bit releases. The bench reaches the first with a task that raises both strobes in one cycle. It reaches the second by programming a very negative therm limit with a large hysteresis and then driving the minimum reading. Random phases then mix updates, reads, combined update-reads and register writes around narrow temperature ranges, so the consecutive-count threshold and hysteresis bands are crossed often.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
  localparam int AW = 8;
  localparam logic [AW-1:0] A_SUMMARY = 8'h00;
  localparam logic [AW-1:0] A_LOWST   = 8'h01;
  localparam logic [AW-1:0] A_CFG     = 8'h02;
  localparam logic [AW-1:0] A_HYST    = 8'h03;
  localparam logic [AW-1:0] A_LOWLIM  = 8'h10;
  localparam logic [AW-1:0] A_THLIM   = 8'h20;
  localparam logic [AW-1:0] A_THST    = 8'h37;
  localparam int HYST_RESET = 10;
endpackage

// File: rtl/tlm_regs.sv
module tlm_regs
  import tlm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int TW  = 8,
  parameter int SW  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [AW-1:0]       addr,
  input  logic [TW-1:0]       wdata,
  output logic [NCH*TW-1:0]   low_lim,
  output logic [NCH*TW-1:0]   th_lim,
  output logic [TW-1:0]       hyst,
  output logic                cmp_mode,
  output logic [SW-1:0]       thresh_m1
);
  localparam logic [TW-1:0] LOW_RST = {1'b1, {(TW-1){1'b0}}};
  localparam logic [TW-1:0] TH_RST  = {1'b0, {(TW-1){1'b1}}};

  for (genvar i = 0; i < NCH; i++) begin : g_lim
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        low_lim[i*TW +: TW] <= LOW_RST;
        th_lim[i*TW +: TW]  <= TH_RST;
      end else if (wr) begin
        if (addr == A_LOWLIM + AW'(i)) low_lim[i*TW +: TW] <= wdata;
        if (addr == A_THLIM + AW'(i))  th_lim[i*TW +: TW]  <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hyst      <= TW'(HYST_RESET);
      cmp_mode  <= 1'b0;
      thresh_m1 <= '0;
    end else if (wr) begin
      if (addr == A_HYST) hyst <= wdata;
      if (addr == A_CFG) begin
        cmp_mode  <= wdata[0];
        thresh_m1 <= wdata[SW:1];
      end
    end
  end
endmodule

// File: rtl/tlm_chan.sv
module tlm_chan #(
  parameter int TW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic signed [TW-1:0] temp,
  input  logic signed [TW-1:0] low_lim,
  input  logic signed [TW-1:0] th_lim,
  input  logic        [TW-1:0] hyst,
  input  logic                 cmp_mode,
  input  logic                 rd_clr,
  output logic                 low_cond,
  output logic                 low_q,
  output logic                 th_q
);
  localparam int XW = TW + 2;
  localparam logic [XW-1:0] MINX = {3'b111, {(TW-1){1'b0}}};
  localparam logic [TW-1:0] MINT = {1'b1, {(TW-1){1'b0}}};

  logic signed [XW-1:0] diff;
  logic signed [TW-1:0] release_pt;
  logic above, below_rel;

  assign diff       = $signed({{2{th_lim[TW-1]}}, th_lim}) - $signed({2'b00, hyst});
  assign release_pt = (diff < $signed(MINX)) ? $signed(MINT) : diff[TW-1:0];
  assign low_cond   = temp < low_lim;
  assign above      = temp > th_lim;
  assign below_rel  = temp < release_pt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= 1'b0;
    end else if (cmp_mode) begin
      if (upd) low_q <= low_cond;
    end else begin
      low_q <= (low_q & ~rd_clr) | (upd & low_cond);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      th_q <= 1'b0;
    end else if (upd) begin
      if (above) th_q <= 1'b1;
      else if (below_rel) th_q <= 1'b0;
    end
  end

  assert_low_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (low_q && !rd_clr && !cmp_mode) |=> low_q);
  assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && low_cond) |=> low_q);
  assert_therm_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && above) |=> th_q);
  assert_therm_only_upd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(th_q));
endmodule

// File: rtl/tlm_alert_qual.sv
module tlm_alert_qual #(
  parameter int CNT_MAX = 4,
  parameter int SW      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic          any_low,
  input  logic [SW-1:0] thresh_m1,
  output logic          qualified
);
  localparam int CW = $clog2(CNT_MAX + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (upd) begin
      if (!any_low) cnt <= '0;
      else if (cnt < CW'(CNT_MAX)) cnt <= cnt + 1'b1;
    end
  end

  assign qualified = (CW + 1)'(cnt) >= (CW + 1)'(thresh_m1) + 1'b1;

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(CNT_MAX));
  assert_clean_resets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !any_low) |=> !qualified);
endmodule

// File: rtl/temp_limit_monitor.sv
module temp_limit_monitor
  import tlm_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int TW      = 8,
  parameter int CNT_MAX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              meas_valid,
  output logic              meas_ready,
  input  logic [NCH*TW-1:0] meas_temp,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [TW-1:0]     reg_wdata,
  output logic [TW-1:0]     reg_rdata,
  output logic              alert_o,
  output logic              therm_o
);
  localparam int SW = $clog2(CNT_MAX);
  localparam int IW = $clog2(NCH);

  logic [NCH*TW-1:0] low_lim, th_lim;
  logic [TW-1:0]     hyst;
  logic              cmp_mode;
  logic [SW-1:0]     thresh_m1;
  logic [NCH-1:0]    low_cond, low_q, th_q;
  logic              upd, rd_clr, qualified;

  assign meas_ready = rst_n;
  assign upd        = meas_valid;
  assign rd_clr     = reg_rd && (reg_addr == A_LOWST) && !cmp_mode;

  tlm_regs #(.NCH(NCH), .TW(TW), .SW(SW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .low_lim(low_lim), .th_lim(th_lim), .hyst(hyst),
    .cmp_mode(cmp_mode), .thresh_m1(thresh_m1)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tlm_chan #(.TW(TW)) u_ch (
      .clk(clk), .rst_n(rst_n), .upd(upd),
      .temp(meas_temp[i*TW +: TW]), .low_lim(low_lim[i*TW +: TW]),
      .th_lim(th_lim[i*TW +: TW]), .hyst(hyst), .cmp_mode(cmp_mode),
      .rd_clr(rd_clr), .low_cond(low_cond[i]), .low_q(low_q[i]), .th_q(th_q[i])
    );
  end

  tlm_alert_qual #(.CNT_MAX(CNT_MAX), .SW(SW)) u_qual (
    .clk(clk), .rst_n(rst_n), .upd(upd), .any_low(|low_cond),
    .thresh_m1(thresh_m1), .qualified(qualified)
  );

  assign alert_o = qualified && (|low_q);
  assign therm_o = |th_q;

  logic [IW-1:0] idx;
  logic          idx_ok;
  assign idx    = reg_addr[IW-1:0];
  assign idx_ok = (reg_addr[3:0] < 4'(NCH));

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_SUMMARY)      reg_rdata = TW'({|th_q, |low_q});
    else if (reg_addr == A_LOWST)   reg_rdata = TW'(low_q);
    else if (reg_addr == A_THST)    reg_rdata = TW'(th_q);
    else if (reg_addr == A_CFG)     reg_rdata = TW'({thresh_m1, cmp_mode});
    else if (reg_addr == A_HYST)    reg_rdata = hyst;
    else if (reg_addr[7:4] == A_LOWLIM[7:4] && idx_ok) reg_rdata = low_lim[idx*TW +: TW];
    else if (reg_addr[7:4] == A_THLIM[7:4] && idx_ok)  reg_rdata = th_lim[idx*TW +: TW];
  end

  assert_alert_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_o) |-> $past(meas_valid || reg_wr));
  assert_therm_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(therm_o) |-> $past(meas_valid));
  assert_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    meas_ready);
endmodule

// File: tb/sim_temp_limit_monitor.sv
module sim_temp_limit_monitor;
  logic clk = 1'b0, rst_n = 1'b0;
  logic meas_valid = 0, reg_wr = 0, reg_rd = 0;
  logic [31:0] meas_temp = '0;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic meas_ready, alert_o, therm_o;
  logic [7:0] reg_rdata;
  int checks = 0, errors = 0;

  int lo[4], th[4], hy, cmpm, nthr, cnt;
  bit elow[4], eth[4];

  always #4 clk = ~clk;

  temp_limit_monitor u0 (
    .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_ready(meas_ready),
    .meas_temp(meas_temp), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alert_o(alert_o), .therm_o(therm_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int s8(int v);
    return (v & 8'h80) ? (v & 8'hFF) - 256 : (v & 8'hFF);
  endfunction

  function automatic int rr(int a, int b);
    return a + int'($urandom % 32'(b - a + 1));
  endfunction

  function automatic int bits_low();
    int r = 0;
    for (int i = 0; i < 4; i++) if (elow[i]) r |= (1 << i);
    return r;
  endfunction

  function automatic int bits_th();
    int r = 0;
    for (int i = 0; i < 4; i++) if (eth[i]) r |= (1 << i);
    return r;
  endfunction

  function automatic int exp_read(int a);
    if (a == 8'h00) return ((bits_th() != 0) << 1) | (bits_low() != 0);
    if (a == 8'h01) return bits_low();
    if (a == 8'h37) return bits_th();
    if (a == 8'h02) return ((nthr - 1) << 1) | cmpm;
    if (a == 8'h03) return hy;
    if (a >= 8'h10 && a < 8'h14) return lo[a - 8'h10] & 8'hFF;
    if (a >= 8'h20 && a < 8'h24) return th[a - 8'h20] & 8'hFF;
    return 0;
  endfunction

  function automatic void model_update(int t[4], bit rd_low);
    bit any = 0;
    if (rd_low && !cmpm) for (int i = 0; i < 4; i++) elow[i] = 0;
    for (int i = 0; i < 4; i++) begin
      int rel = th[i] - hy;
      bit lc = t[i] < lo[i];
      if (rel < -128) rel = -128;
      any |= lc;
      if (cmpm) elow[i] = lc; else elow[i] |= lc;
      if (t[i] > th[i]) eth[i] = 1;
      else if (t[i] < rel) eth[i] = 0;
    end
    cnt = any ? ((cnt < 4) ? cnt + 1 : 4) : 0;
  endfunction

  function automatic void model_write(int a, int d);
    if (a == 8'h02) begin cmpm = d & 1; nthr = ((d >> 1) & 3) + 1; end
    if (a == 8'h03) hy = d & 8'hFF;
    if (a >= 8'h10 && a < 8'h14) lo[a - 8'h10] = s8(d);
    if (a >= 8'h20 && a < 8'h24) th[a - 8'h20] = s8(d);
  endfunction

  task automatic pins(string req);
    check({req, " alert_o"}, alert_o, (cnt >= nthr) && (bits_low() != 0));
    check({req, " therm_o"}, therm_o, bits_th() != 0);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 8'(a); reg_wdata = 8'(d);
    @(posedge clk); #1 reg_wr = 0;
    model_write(a, d);
  endtask

  task automatic rd(string req, int a);
    int got;
    @(negedge clk);
    reg_rd = 1; reg_addr = 8'(a);
    #1 got = int'(reg_rdata);
    check({req, " read"}, got, exp_read(a));
    @(posedge clk); #1 reg_rd = 0;
    if (a == 8'h01 && !cmpm) for (int i = 0; i < 4; i++) elow[i] = 0;
  endtask

  task automatic upd(int t[4], bit with_rd, string req);
    int got;
    @(negedge clk);
    meas_valid = 1;
    for (int i = 0; i < 4; i++) meas_temp[i*8 +: 8] = 8'(t[i]);
    if (with_rd) begin reg_rd = 1; reg_addr = 8'h01; end
    #1 got = int'(reg_rdata);
    if (with_rd) check({req, " read-before-edge"}, got, bits_low());
    @(posedge clk); #1 meas_valid = 0; reg_rd = 0;
    model_update(t, with_rd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin lo[i] = -128; th[i] = 127; elow[i] = 0; eth[i] = 0; end
    hy = 10; cmpm = 0; nthr = 1; cnt = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R11 meas_ready", meas_ready, 1);
    // R10 reset values
    rd("R10", 8'h10); rd("R10", 8'h23); rd("R10", 8'h03); rd("R10", 8'h02);
    rd("R10", 8'h01); rd("R10", 8'h37); rd("R7", 8'h00); rd("R10", 8'h55);
    @(negedge clk); pins("R10");
    // program limits
    for (int i = 0; i < 4; i++) begin wr(8'h10 + i, 20); wr(8'h20 + i, 50); end
    wr(8'h03, 5);
    rd("R10", 8'h11); rd("R10", 8'h22); rd("R10", 8'h03);
    // R1 one channel low, R9 alert with N=1
    upd('{25, 10, 25, 25}, 0, "R1");
    @(negedge clk); pins("R9");
    rd("R1", 8'h01); rd("R7", 8'h00);
    // R2 the read cleared the bits
    rd("R2", 8'h01);
    @(negedge clk); pins("R2");
    // R3 set wins over same-cycle clear
    upd('{25, 25, 25, 5}, 0, "R3");
    upd('{25, 25, 5, 25}, 1, "R3");
    rd("R3", 8'h01);
    // R1 signed compare: limit -10, reading 5 not low, -20 low
    wr(8'h10, 8'hF6);
    upd('{5, 25, 25, 25}, 0, "R1");
    rd("R1", 8'h01);
    upd('{-20, 25, 25, 25}, 0, "R1");
    rd("R1", 8'h01);
    // R5/R6/R8 hysteresis on channel 2
    upd('{30, 30, 60, 30}, 0, "R5");
    @(negedge clk); pins("R8");
    upd('{30, 30, 47, 30}, 0, "R5");
    rd("R6", 8'h37); rd("R6", 8'h37); rd("R7", 8'h00);
    upd('{30, 30, 44, 30}, 0, "R5");
    rd("R5", 8'h37);
    @(negedge clk); pins("R8");
    // R5 saturated release point: limit -120, hyst 20 -> -128
    wr(8'h23, 8'h88); wr(8'h03, 20);
    upd('{30, 30, 30, -100}, 0, "R5");
    upd('{30, 30, 30, -128}, 0, "R5");
    rd("R5 saturation", 8'h37);
    wr(8'h23, 50); wr(8'h03, 5);
    // R9 threshold of 3 consecutive
    wr(8'h02, 8'h04);
    rd("R2", 8'h01);
    upd('{30, 0, 30, 30}, 0, "R9"); @(negedge clk); pins("R9 count1");
    upd('{30, 0, 30, 30}, 0, "R9"); @(negedge clk); pins("R9 count2");
    upd('{30, 0, 30, 30}, 0, "R9"); @(negedge clk); pins("R9 count3");
    upd('{30, 30, 30, 30}, 0, "R9"); @(negedge clk); pins("R9 reset");
    // R4 follow mode
    wr(8'h02, 8'h01);
    upd('{30, 30, 0, 30}, 0, "R4");
    rd("R4", 8'h01); rd("R4", 8'h01);
    upd('{30, 30, 30, 30}, 0, "R4");
    rd("R4", 8'h01);
    wr(8'h02, 0);
    // random phase
    for (int n = 0; n < 600; n++) begin
      int op = rr(0, 9);
      int t[4];
      for (int i = 0; i < 4; i++) t[i] = rr(-10, 70);
      if (op < 4) upd(t, 0, "R1 R5 R9 random");
      else if (op < 5) upd(t, 1, "R3 random");
      else if (op < 8) begin
        int sel = rr(0, 5);
        int a = (sel == 0) ? 8'h00 : (sel == 1) ? 8'h01 : (sel == 2) ? 8'h37 :
                (sel == 3) ? 8'h02 : (sel == 4) ? 8'h10 + rr(0, 3) : 8'h20 + rr(0, 3);
        rd("R2 R6 R7 random", a);
      end else begin
        int sel = rr(0, 3);
        if (sel == 0) wr(8'h02, rr(0, 7));
        else if (sel == 1) wr(8'h03, rr(0, 15));
        else if (sel == 2) wr(8'h10 + rr(0, 3), rr(0, 30) & 8'hFF);
        else wr(8'h20 + rr(0, 3), rr(30, 60));
      end
      @(negedge clk); pins("R8 R9 random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule